// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits behind the asynchronous write port of a NOR-style flash device. It watches bus write cycles, which arrive as an active-low chip enable and an active-low write enable with an address and a data byte. It follows the unlock and command sequences and raises one-cycle requests toward the program and erase engines. Each request carries the address and data of the write that completed the sequence. A two-flop synchroniser brings the combined strobe into the internal clock domain. The write address is taken when the strobe asserts and the write data when it releases.

The decoder holds a small state for the operation in progress. While a program or a whole-array erase runs, every write is dropped. While a sector erase runs, only the suspend code is honoured. Once the erase is suspended, the interface accepts program commands aimed at other sectors, a resume code, and the reset code. A fast-program (bypass) mode cuts a program down to two writes. The mode lasts until an exit code followed by the reset code. The `ready` output is low while any engine is working.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset `ready` is 1, `bypass_active` and `erase_suspended` are 0, and no request pulses.
- R2: The write strobe is asserted while both `bus_ce_n` and `bus_we_n` are low, so whichever of the two acts last opens the cycle and whichever acts first closes it. A request carries the address present when the strobe asserted and the data present when it released.
- R3: The writes AAh@555h, 55h@2AAh, A0h@555h, then D@A, produce exactly one `prog_req` with `req_addr`=A and `req_data`=D.
- R4: A write that does not match the next expected step of a sequence returns the decoder to idle, so later steps of that sequence produce no request.
- R5: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h@S give one `sect_erase_req` with address S. Ending instead with 10h@555h gives one `chip_erase_req`.
- R6: After unlock, 20h@555h enters bypass (`bypass_active`=1). In bypass, A0h at any address followed by D@A gives one `prog_req`.
- R7: In bypass, 90h followed by F0h leaves bypass. F0h alone keeps bypass.
- R8: While a program or a chip erase is in progress, every write is ignored, including the suspend code.
- R9: While a sector erase is in progress, only B0h is honoured. It pulses `suspend_req`, after which `ready`=1 and `erase_suspended`=1.
- R10: While suspended, a program into the erasing sector (sector = address bits above SECT_SHIFT) is ignored, and a program into any other sector is issued. 30h at any address pulses `resume_req` and busies the block again.
- R11: `ready` goes low after a program or erase request and returns high after `prog_done` or `erase_done`.
- R12: F0h in the middle of a sequence, while not busy, returns the decoder to idle.
- R13: A write whose decode falls in the same cycle as an engine's completion is judged against the busy state. A B0h coinciding with `erase_done` gives no suspend.
- R14: Request outputs are single-cycle pulses, and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_addr | input | AW | Bus word address |
| bus_data | input | DW | Bus write data |
| prog_done | input | 1 | Program engine finished (one cycle) |
| erase_done | input | 1 | Erase engine finished (one cycle) |
| prog_req | output | 1 | Program request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| chip_erase_req | output | 1 | Whole-array erase request pulse |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| req_addr | output | AW | Address carried by the last request |
| req_data | output | DW | Data carried by the last request |
| ready | output | 1 | High when no engine is working |
| bypass_active | output | 1 | Fast-program mode active |
| erase_suspended | output | 1 | A sector erase is suspended |

## Verification
The two functions that can share a cycle are the decode of a synchronised write and the completion strobe of an engine. The bench places `prog_done` or `erase_done` in exactly the cycle in which the released strobe reaches the decoder: once under the last write of a program sequence issued during a program, and once under a suspend code during a sector erase. Both are judged at the ports. No request may appear, `ready` must return high, and `erase_suspended` must stay low.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM,
    SQ_ERS1, SQ_ERS2, SQ_ERS3,
    SQ_BYP, SQ_BYP_PGM, SQ_BYP_EXIT
  } seq_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_ERASE, OP_CHIP, OP_SUSP, OP_SUSP_PROG
  } op_e;

  typedef struct packed {
    logic prog;
    logic sect;
    logic chip;
    logic susp;
    logic resume;
  } req_t;

  localparam logic [7:0] CODE_KEY1    = 8'hAA;
  localparam logic [7:0] CODE_KEY2    = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_BYPASS  = 8'h20;
  localparam logic [7:0] CODE_BYP_OUT = 8'h90;
  localparam logic [7:0] CODE_RESET   = 8'hF0;
  localparam logic [7:0] CODE_SUSPEND = 8'hB0;
  localparam logic [7:0] CODE_RESUME  = 8'h30;

endpackage

// File: rtl/fci_strobe_cap.sv
module fci_strobe_cap #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int SHW = SYNC_STAGES + 1;

  logic           strobe_n;
  logic [SHW-1:0] sh_q;
  logic           fall, rise;

  assign strobe_n = ce_n | we_n;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[SHW-2:0], strobe_n};
  end

  assign fall = sh_q[SHW-1] & ~sh_q[SHW-2];
  assign rise = ~sh_q[SHW-1] & sh_q[SHW-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      wr_data <= '0;
      wr_evt  <= 1'b0;
    end else begin
      wr_evt <= rise;
      if (fall) wr_addr <= addr;
      if (rise) wr_data <= data;
    end
  end
endmodule

// File: rtl/fci_decoder.sv
module fci_decoder
  import fci_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int SECT_SHIFT = 8,
  parameter int KEY_ADDR1 = 'h555,
  parameter int KEY_ADDR2 = 'h2AA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          prog_done,
  input  logic          erase_done,
  output req_t          req,
  output logic          idle_now,
  output logic          bypass_now,
  output logic          susp_now
);
  localparam int SW = AW - SECT_SHIFT;

  seq_e          seq_q, seq_n;
  op_e           op_q, op_n;
  logic [SW-1:0] ers_q, ers_n;

  logic [7:0]    code;
  logic          at_k1, at_k2, in_susp, in_byp;
  seq_e          home;

  assign code    = wr_data[7:0];
  assign at_k1   = (wr_addr == AW'(KEY_ADDR1));
  assign at_k2   = (wr_addr == AW'(KEY_ADDR2));
  assign in_susp = (op_q == OP_SUSP);
  assign in_byp  = (seq_q == SQ_BYP) || (seq_q == SQ_BYP_PGM) || (seq_q == SQ_BYP_EXIT);
  assign home    = in_byp ? SQ_BYP : SQ_IDLE;

  always_comb begin
    seq_n = seq_q;
    op_n  = op_q;
    ers_n = ers_q;
    req   = '0;
    if (wr_evt) begin
      case (op_q)
        OP_PROG, OP_SUSP_PROG, OP_CHIP: ;
        OP_ERASE: begin
          if (code == CODE_SUSPEND) begin
            req.susp = 1'b1;
            op_n     = OP_SUSP;
          end
        end
        default: begin
          if (seq_q == SQ_PGM || seq_q == SQ_BYP_PGM) begin
            seq_n = home;
            if (!(in_susp && wr_addr[AW-1:SECT_SHIFT] == ers_q)) begin
              req.prog = 1'b1;
              op_n     = in_susp ? OP_SUSP_PROG : OP_PROG;
            end
          end else if (code == CODE_RESET) begin
            seq_n = (seq_q == SQ_BYP_EXIT) ? SQ_IDLE : home;
          end else begin
            case (seq_q)
              SQ_IDLE: begin
                if (in_susp && code == CODE_RESUME) begin
                  req.resume = 1'b1;
                  op_n       = OP_ERASE;
                end else if (code == CODE_KEY1 && at_k1) begin
                  seq_n = SQ_UNL1;
                end
              end
              SQ_UNL1: seq_n = (code == CODE_KEY2 && at_k2) ? SQ_UNL2 : SQ_IDLE;
              SQ_UNL2: begin
                if (at_k1 && code == CODE_PROG)                     seq_n = SQ_PGM;
                else if (at_k1 && code == CODE_ERASE && !in_susp)   seq_n = SQ_ERS1;
                else if (at_k1 && code == CODE_BYPASS && !in_susp)  seq_n = SQ_BYP;
                else                                                seq_n = SQ_IDLE;
              end
              SQ_ERS1: seq_n = (code == CODE_KEY1 && at_k1) ? SQ_ERS2 : SQ_IDLE;
              SQ_ERS2: seq_n = (code == CODE_KEY2 && at_k2) ? SQ_ERS3 : SQ_IDLE;
              SQ_ERS3: begin
                seq_n = SQ_IDLE;
                if (code == CODE_SECTOR) begin
                  req.sect = 1'b1;
                  op_n     = OP_ERASE;
                  ers_n    = wr_addr[AW-1:SECT_SHIFT];
                end else if (code == CODE_CHIP && at_k1) begin
                  req.chip = 1'b1;
                  op_n     = OP_CHIP;
                end
              end
              SQ_BYP: begin
                if (code == CODE_PROG)         seq_n = SQ_BYP_PGM;
                else if (code == CODE_BYP_OUT) seq_n = SQ_BYP_EXIT;
              end
              SQ_BYP_EXIT: seq_n = SQ_BYP;
              default: seq_n = SQ_IDLE;
            endcase
          end
        end
      endcase
    end
    // engine completion takes precedence over a write decoded in the same cycle
    if (prog_done && op_q == OP_PROG)      op_n = OP_NONE;
    if (prog_done && op_q == OP_SUSP_PROG) op_n = OP_SUSP;
    if (erase_done && (op_q == OP_ERASE || op_q == OP_CHIP)) begin
      op_n     = OP_NONE;
      req.susp = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SQ_IDLE;
      op_q  <= OP_NONE;
      ers_q <= '0;
    end else begin
      seq_q <= seq_n;
      op_q  <= op_n;
      ers_q <= ers_n;
    end
  end

  assign idle_now   = (op_q == OP_NONE) || (op_q == OP_SUSP);
  assign bypass_now = in_byp;
  assign susp_now   = (op_q == OP_SUSP) || (op_q == OP_SUSP_PROG);
endmodule

// File: rtl/fci_out_reg.sv
module fci_out_reg
  import fci_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  req_t          req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          idle_now,
  input  logic          bypass_now,
  input  logic          susp_now,
  output req_t          req_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          ready_q,
  output logic          bypass_q,
  output logic          susp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      ready_q  <= 1'b1;
      bypass_q <= 1'b0;
      susp_q   <= 1'b0;
    end else begin
      req_q    <= req;
      ready_q  <= idle_now;
      bypass_q <= bypass_now;
      susp_q   <= susp_now;
      if (|req) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int SECT_SHIFT = 8,
  parameter int SYNC_STAGES = 2,
  parameter int KEY_ADDR1 = 'h555,
  parameter int KEY_ADDR2 = 'h2AA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          prog_done,
  input  logic          erase_done,
  output logic          prog_req,
  output logic          sect_erase_req,
  output logic          chip_erase_req,
  output logic          suspend_req,
  output logic          resume_req,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          ready,
  output logic          bypass_active,
  output logic          erase_suspended
);
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  req_t          req, req_q;
  logic          idle_now, bypass_now, susp_now;

  fci_strobe_cap #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .ce_n(bus_ce_n), .we_n(bus_we_n),
    .addr(bus_addr), .data(bus_data),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fci_decoder #(.AW(AW), .DW(DW), .SECT_SHIFT(SECT_SHIFT),
                .KEY_ADDR1(KEY_ADDR1), .KEY_ADDR2(KEY_ADDR2)) u_dec (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_done(prog_done), .erase_done(erase_done), .req(req),
    .idle_now(idle_now), .bypass_now(bypass_now), .susp_now(susp_now)
  );

  fci_out_reg #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .req(req), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle_now(idle_now), .bypass_now(bypass_now), .susp_now(susp_now),
    .req_q(req_q), .addr_q(req_addr), .data_q(req_data),
    .ready_q(ready), .bypass_q(bypass_active), .susp_q(erase_suspended)
  );

  assign prog_req       = req_q.prog;
  assign sect_erase_req = req_q.sect;
  assign chip_erase_req = req_q.chip;
  assign suspend_req    = req_q.susp;
  assign resume_req     = req_q.resume;
endmodule

// File: rtl/fci_checker.sv
module fci_checker (
  input logic clk,
  input logic rst,
  input logic prog_req,
  input logic sect_erase_req,
  input logic chip_erase_req,
  input logic suspend_req,
  input logic resume_req,
  input logic ready,
  input logic bypass_active,
  input logic erase_suspended
);
  logic [4:0] reqs;
  assign reqs = {prog_req, sect_erase_req, chip_erase_req, suspend_req, resume_req};

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst) $onehot0(reqs)); // R14
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) (|reqs) |=> !(|reqs)); // R14
  AST_PROG_WHEN_FREE: assert property (@(posedge clk) disable iff (rst) prog_req |-> ready); // R8
  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (rst) prog_req |=> !ready); // R11
  AST_CHIP_BUSY: assert property (@(posedge clk) disable iff (rst) chip_erase_req |=> !ready); // R5
  AST_SECT_NO_BYPASS: assert property (@(posedge clk) disable iff (rst) sect_erase_req |-> !bypass_active); // R6
  AST_SUSP_RELEASE: assert property (@(posedge clk) disable iff (rst) suspend_req |=> (ready && erase_suspended)); // R9
  AST_SUSP_FROM_BUSY: assert property (@(posedge clk) disable iff (rst) suspend_req |-> !ready); // R9
  AST_RESUME_SUSP: assert property (@(posedge clk) disable iff (rst) resume_req |-> erase_suspended); // R10
endmodule

bind flash_cmd_if fci_checker u_chk (
  .clk(clk), .rst(rst), .prog_req(prog_req), .sect_erase_req(sect_erase_req),
  .chip_erase_req(chip_erase_req), .suspend_req(suspend_req), .resume_req(resume_req),
  .ready(ready), .bypass_active(bypass_active), .erase_suspended(erase_suspended)
);

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_ce_n = 1'b1, bus_we_n = 1'b1;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        prog_done = 1'b0, erase_done = 1'b0;
  logic        prog_req, sect_erase_req, chip_erase_req, suspend_req, resume_req;
  logic [10:0] req_addr;
  logic [7:0]  req_data;
  logic        ready, bypass_active, erase_suspended;

  int n_checks = 0, n_fail = 0;
  int n_prog = 0, n_sect = 0, n_chip = 0, n_susp = 0, n_res = 0, n_multi = 0, n_back = 0;
  logic prev_any = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_if u0 (
    .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .prog_done(prog_done), .erase_done(erase_done),
    .prog_req(prog_req), .sect_erase_req(sect_erase_req), .chip_erase_req(chip_erase_req),
    .suspend_req(suspend_req), .resume_req(resume_req), .req_addr(req_addr), .req_data(req_data),
    .ready(ready), .bypass_active(bypass_active), .erase_suspended(erase_suspended)
  );

  always @(negedge clk) begin
    if (!rst) begin
      int c;
      c = prog_req + sect_erase_req + chip_erase_req + suspend_req + resume_req;
      n_prog += prog_req; n_sect += sect_erase_req; n_chip += chip_erase_req;
      n_susp += suspend_req; n_res += resume_req;
      if (c > 1) n_multi++;
      if (c > 0 && prev_any) n_back++;
      prev_any = (c > 0);
    end
  end

  function automatic int tot();
    return n_prog + n_sect + n_chip + n_susp + n_res;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inj: 0 none, 1 prog_done, 2 erase_done in the decode cycle of this write
  task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit by_ce, input int inj);
    @(negedge clk);
    bus_addr = a; bus_data = ~d;
    if (by_ce) begin bus_we_n = 1'b0; @(negedge clk); bus_ce_n = 1'b0; end
    else       begin bus_ce_n = 1'b0; @(negedge clk); bus_we_n = 1'b0; end
    repeat (5) @(negedge clk);
    bus_addr = ~a; bus_data = d;
    repeat (2) @(negedge clk);
    if (by_ce) bus_ce_n = 1'b1; else bus_we_n = 1'b1;
    if (inj != 0) begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (inj == 1) prog_done = 1'b1; else erase_done = 1'b1;
      @(negedge clk);
      prog_done = 1'b0; erase_done = 1'b0;
    end
    repeat (4) @(negedge clk);
    bus_ce_n = 1'b1; bus_we_n = 1'b1; bus_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic w(input logic [10:0] a, input logic [7:0] d);
    wr(a, d, 1'b0, 0);
  endtask

  task automatic unl();
    w(11'h555, 8'hAA); w(11'h2AA, 8'h55);
  endtask

  task automatic done(input int kind);
    @(negedge clk);
    if (kind == 1) prog_done = 1'b1; else erase_done = 1'b1;
    @(negedge clk);
    prog_done = 1'b0; erase_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic erase_seq(input logic [10:0] a, input logic [7:0] d);
    unl(); w(11'h555, 8'h80); unl(); w(a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(bypass_active == 1'b0 && erase_suspended == 1'b0, "R1 flags", {bypass_active, erase_suspended}, 0);
    check(tot() == 0, "R1 no request", tot(), 0);

    // R3 / R2 four-write program via write enable
    unl(); w(11'h555, 8'hA0); w(11'h123, 8'h5A);
    check(n_prog == 1, "R3 prog count", n_prog, 1);
    check(req_addr == 11'h123 && req_data == 8'h5A, "R2 addr/data", {req_addr, req_data}, {11'h123, 8'h5A});
    check(ready == 1'b0, "R11 busy", ready, 0);
    // R8 everything ignored while programming
    b = tot();
    unl(); w(11'h555, 8'hA0); w(11'h044, 8'h11); w(11'h0, 8'hB0);
    check(tot() == b, "R8 ignored in program", tot(), b);
    done(1);
    check(ready == 1'b1, "R11 ready after done", ready, 1);

    // R2 strobe by chip enable
    wr(11'h555, 8'hAA, 1'b1, 0); wr(11'h2AA, 8'h55, 1'b1, 0);
    wr(11'h555, 8'hA0, 1'b1, 0); wr(11'h0F1, 8'hC3, 1'b1, 0);
    check(n_prog == 2 && req_addr == 11'h0F1 && req_data == 8'hC3, "R2 chip enable strobe",
          {req_addr, req_data}, {11'h0F1, 8'hC3});
    done(1);

    // R4 broken sequence
    b = tot();
    w(11'h555, 8'hAA); w(11'h2AB, 8'h55); w(11'h555, 8'hA0); w(11'h010, 8'h99);
    check(tot() == b && ready == 1'b1, "R4 broken unlock", tot(), b);

    // R12 reset mid-sequence
    unl(); w(11'h555, 8'hF0); w(11'h555, 8'hA0); w(11'h100, 8'h34);
    check(tot() == b, "R12 reset aborts", tot(), b);

    // R5 sector erase, R9 suspend, R10 suspended behaviour
    erase_seq(11'h300, 8'h30);
    check(n_sect == 1 && req_addr == 11'h300, "R5 sector erase", {n_sect, req_addr}, {32'd1, 11'h300});
    check(ready == 1'b0, "R11 erase busy", ready, 0);
    b = tot();
    unl(); w(11'h555, 8'hA0); w(11'h044, 8'h11); w(11'h0, 8'h30);
    check(tot() == b, "R9 only suspend honoured", tot(), b);
    w(11'h020, 8'hB0);
    check(n_susp == 1, "R9 suspend pulse", n_susp, 1);
    check(ready == 1'b1 && erase_suspended == 1'b1, "R9 suspended ready", {ready, erase_suspended}, 3);
    b = tot();
    unl(); w(11'h555, 8'hA0); w(11'h3AA, 8'h66);
    check(tot() == b, "R10 same sector ignored", tot(), b);
    unl(); w(11'h555, 8'hA0); w(11'h155, 8'h67);
    check(n_prog == 3 && req_addr == 11'h155, "R10 other sector program", req_addr, 11'h155);
    check(ready == 1'b0, "R10 busy while suspended program", ready, 0);
    done(1);
    check(ready == 1'b1 && erase_suspended == 1'b1, "R10 back to suspended", {ready, erase_suspended}, 3);
    w(11'h000, 8'h30);
    check(n_res == 1 && ready == 1'b0, "R10 resume", {n_res, ready}, {32'd1, 1'b0});
    done(2);
    check(ready == 1'b1 && erase_suspended == 1'b0, "R11 erase complete", {ready, erase_suspended}, 2);

    // R5 chip erase, R8 no suspend
    erase_seq(11'h555, 8'h10);
    check(n_chip == 1, "R5 chip erase", n_chip, 1);
    w(11'h0, 8'hB0);
    check(n_susp == 1, "R8 chip erase ignores suspend", n_susp, 1);
    done(2);

    // R6 / R7 bypass
    unl(); w(11'h555, 8'h20);
    check(bypass_active == 1'b1, "R6 bypass entered", bypass_active, 1);
    w(11'h000, 8'hA0); w(11'h0F0, 8'h77);
    check(n_prog == 4 && req_addr == 11'h0F0 && req_data == 8'h77, "R6 two-write program",
          {req_addr, req_data}, {11'h0F0, 8'h77});
    done(1);
    w(11'h000, 8'hF0);
    check(bypass_active == 1'b1, "R7 reset alone keeps bypass", bypass_active, 1);
    w(11'h000, 8'hA0); w(11'h0F2, 8'h78);
    check(n_prog == 5, "R7 still bypass", n_prog, 5);
    done(1);
    w(11'h000, 8'h90); w(11'h000, 8'hF0);
    check(bypass_active == 1'b0, "R7 bypass left", bypass_active, 0);
    w(11'h000, 8'hA0); w(11'h0F3, 8'h79);
    check(n_prog == 5, "R7 no short program after exit", n_prog, 5);

    // R13 coincidences
    unl(); w(11'h555, 8'hA0); w(11'h011, 8'h22);
    b = tot();
    unl(); w(11'h555, 8'hA0); wr(11'h012, 8'h23, 1'b0, 1);
    check(tot() == b && ready == 1'b1, "R13 write with prog_done ignored", tot(), b);
    erase_seq(11'h200, 8'h30);
    b = tot();
    wr(11'h000, 8'hB0, 1'b0, 2);
    check(tot() == b && ready == 1'b1 && erase_suspended == 1'b0, "R13 suspend with erase_done",
          {tot() - b, erase_suspended}, 0);

    // sweep of the command byte after unlock: R3 R4 R6
    for (int d = 0; d < 256; d++) begin
      bit ep, eb;
      ep = (d == 8'hA0);
      eb = (d == 8'h20);
      b = tot();
      unl(); w(11'h555, d[7:0]); w(11'h100, 8'h30);
      check(tot() - b == int'(ep), "R3/R4 sweep requests", tot() - b, int'(ep));
      check(bypass_active == eb, "R6 sweep bypass", bypass_active, eb);
      if (ep) done(1);
      if (eb) begin w(11'h0, 8'h90); w(11'h0, 8'hF0); end
      w(11'h0, 8'hF0);
    end

    check(n_multi == 0, "R14 one request per cycle", n_multi, 0);
    check(n_back == 0, "R14 single-cycle pulses", n_back, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule